// File: doc/BRIEF.md
# Two-Wire Bus Attach/Detach Detector

This block watches the clock and data lines of a two-wire serial bus and decides whether a partner is physically attached. When both lines sit low without a break for a programmable number of 1 ms timebase ticks, the bus is declared detached. When either line is seen high again while detached, the bus is declared attached.

A single sticky event flag records one of the two transitions. A polarity bit selects which one: attach or detach. The flag drives an interrupt request that is gated by a local enable and by a processor-wide enable. Both lines pass through two-stage synchronizers before any decision is made. The block does not decode bus traffic and does not drive the pads.

Top module: `bus_attach_detect`

## Requirements
- R1: Each bus line passes through two flip-flop stages before detection. A low level applied before clock edge k is first counted at edge k+2 when a tick is present.
- R2: A detach is declared at the edge where the count of ticks seen with both synchronized lines low reaches the limit. The limit is set by the 2-bit select field: 0 gives 250, 1 gives 500, 2 gives 1000 and 3 gives 2000 ticks. The block then leaves the attached state, so `attached` goes to 0.
- R3: If either synchronized line is high while attached, the low-time count returns to zero, so a later detach again needs the full limit.
- R4: While detached, either synchronized line high declares an attach in that cycle, and the block returns to the attached state.
- R5: With polarity bit 0, the event flag sets on an attach. With polarity bit 1, it sets on a detach. The other transition leaves the flag unchanged.
- R6: The event flag holds until `flag_clr` is pulsed. If a set and a clear fall in the same cycle, the flag ends set.
- R7: `irq` is 1 exactly when the event flag, the enable bit and `global_ie` are all 1.
- R8: The control register holds the enable at bit 6, the select field at bits 2:1 and polarity at bit 0. Bit 7 and bits 5:3 read as 0.
- R9: A control write that changes the select field clears the low-time count in that cycle, so counting starts again from zero.
- R10: After reset the block is attached, the flag is 0, `irq` is 0 and the control register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Raw bus clock line level |
| sda_in | input | 1 | Raw bus data line level |
| tick_1ms | input | 1 | One-cycle timebase enable, nominally every 1 ms |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| flag_clr | input | 1 | Clears the event flag (write-one-to-clear strobe) |
| global_ie | input | 1 | Processor-wide interrupt enable |
| ctrl_rdata | output | 8 | Control register read value |
| event_flag | output | 1 | Sticky attach/detach event flag |
| attached | output | 1 | 1 while the bus is considered attached |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `tick_1ms` is a single-cycle enable, and that `flag_clr`, `ctrl_wr` and `global_ie` are stable around the sampling edge. They also assume that the bus lines may change in any cycle, since the synchronizers absorb the asynchrony. The stimulus drives every input at the falling clock edge, so each value is settled long before the rising edge that samples it. Random phases hold both lines low for lengths that fall on either side of the selected limit, with ticks present on most cycles. Directed cases place a clear on the same edge as a set, and place a select change in the middle of a low period.

// File: rtl/bad_pkg.sv
package bad_pkg;

  localparam int unsigned SEL_W = 2;

  typedef enum logic {
    LINK_DOWN = 1'b0,
    LINK_UP   = 1'b1
  } link_e;

  typedef struct packed {
    logic             ie;
    logic [SEL_W-1:0] sel;
    logic             pol;
  } ctrl_t;

  // tick count needed before a detach is declared
  function automatic int unsigned low_limit(input int unsigned base,
                                            input logic [SEL_W-1:0] sel);
    return base << sel;
  endfunction

  // read-back layout: enable at 6, select at 2:1, polarity at 0
  function automatic logic [7:0] pack_ctrl(input ctrl_t c);
    return {1'b0, c.ie, 3'b000, c.sel, c.pol};
  endfunction

endpackage

// File: rtl/bad_sync.sv
module bad_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] INIT  = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) pipe_q[i] <= INIT;
    end else begin
      pipe_q[0] <= din;
      for (int i = 1; i < int'(STAGES); i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/bad_lowtimer.sv
module bad_lowtimer
  import bad_pkg::*;
#(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             both_low,
  input  logic             tick,
  input  logic             restart,
  input  int unsigned      limit,
  output logic [CNT_W-1:0] cnt_o,
  output logic             attached_o,
  output logic             disc_evt,
  output logic             conn_evt
);

  link_e            link_q, link_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             reach;

  assign reach = (32'(cnt_q) + 32'd1) == limit;

  always_comb begin
    link_d   = link_q;
    cnt_d    = cnt_q;
    disc_evt = 1'b0;
    conn_evt = 1'b0;
    if (link_q == LINK_UP) begin
      if (!both_low || restart) begin
        cnt_d = '0;
      end else if (tick) begin
        if (reach) begin
          disc_evt = 1'b1;
          link_d   = LINK_DOWN;
          cnt_d    = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
    end else begin
      cnt_d = '0;
      if (!both_low) begin
        conn_evt = 1'b1;
        link_d   = LINK_UP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= LINK_UP;
      cnt_q  <= '0;
    end else begin
      link_q <= link_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign attached_o = (link_q == LINK_UP);

endmodule

// File: rtl/bad_evtflag.sv
module bad_evtflag (
  input  logic clk,
  input  logic rst_n,
  input  logic conn_evt,
  input  logic disc_evt,
  input  logic pol,
  input  logic clr,
  input  logic ie,
  input  logic gie,
  output logic set_evt,
  output logic flag_o,
  output logic irq_o
);

  logic flag_q;

  assign set_evt = pol ? disc_evt : conn_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr)     flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ie & gie;

endmodule

// File: rtl/bus_attach_detect.sv
module bus_attach_detect
  import bad_pkg::*;
#(
  parameter int unsigned BASE_TICKS  = 250,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       tick_1ms,
  input  logic       ctrl_wr,
  input  logic [7:0] ctrl_wdata,
  input  logic       flag_clr,
  input  logic       global_ie,
  output logic [7:0] ctrl_rdata,
  output logic       event_flag,
  output logic       attached,
  output logic       irq
);

  localparam int unsigned MAX_LIMIT = BASE_TICKS << ((1 << SEL_W) - 1);
  localparam int unsigned CNT_W     = $clog2(MAX_LIMIT + 1);

  ctrl_t            ctrl_q;
  logic [1:0]       line_s;
  logic             both_low;
  logic             restart;
  int unsigned      limit;
  logic [CNT_W-1:0] cnt;
  logic             disc_evt, conn_evt, set_evt;

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q.ie  <= ctrl_wdata[6];
      ctrl_q.sel <= ctrl_wdata[2:1];
      ctrl_q.pol <= ctrl_wdata[0];
    end
  end

  assign ctrl_rdata = pack_ctrl(ctrl_q);
  assign restart    = ctrl_wr && (ctrl_wdata[2:1] != ctrl_q.sel);
  assign limit      = low_limit(BASE_TICKS, ctrl_q.sel);

  bad_sync #(
    .W      (2),
    .STAGES (SYNC_STAGES),
    .INIT   (2'b11)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({scl_in, sda_in}),
    .dout  (line_s)
  );

  assign both_low = (line_s == 2'b00);

  bad_lowtimer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .both_low   (both_low),
    .tick       (tick_1ms),
    .restart    (restart),
    .limit      (limit),
    .cnt_o      (cnt),
    .attached_o (attached),
    .disc_evt   (disc_evt),
    .conn_evt   (conn_evt)
  );

  bad_evtflag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .conn_evt (conn_evt),
    .disc_evt (disc_evt),
    .pol      (ctrl_q.pol),
    .clr      (flag_clr),
    .ie       (ctrl_q.ie),
    .gie      (global_ie),
    .set_evt  (set_evt),
    .flag_o   (event_flag),
    .irq_o    (irq)
  );

endmodule

// File: rtl/bad_checker.sv
module bad_checker #(
  parameter int unsigned CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             both_low,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input int unsigned      limit,
  input logic             attached,
  input logic             disc_evt,
  input logic             conn_evt,
  input logic             set_evt,
  input logic             event_flag,
  input logic             flag_clr,
  input logic [7:0]       ctrl_rdata,
  input logic             global_ie,
  input logic             irq
);

  assert_detach_needs_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    disc_evt |-> (both_low && tick && attached));

  assert_detach_leaves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    disc_evt |=> !attached);

  assert_count_below_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < limit);

  assert_high_clears_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !both_low |=> (cnt == '0));

  assert_reattach_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!attached && !both_low) |=> attached);

  assert_attach_pol_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (conn_evt && !ctrl_rdata[0]) |=> event_flag);

  assert_detach_pol_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (disc_evt && ctrl_rdata[0]) |=> event_flag);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (event_flag && !flag_clr) |=> event_flag);

  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !set_evt) |=> !event_flag);

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (event_flag && ctrl_rdata[6] && global_ie));

endmodule

bind bus_attach_detect bad_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .both_low   (both_low),
  .tick       (tick_1ms),
  .cnt        (cnt),
  .limit      (limit),
  .attached   (attached),
  .disc_evt   (disc_evt),
  .conn_evt   (conn_evt),
  .set_evt    (set_evt),
  .event_flag (event_flag),
  .flag_clr   (flag_clr),
  .ctrl_rdata (ctrl_rdata),
  .global_ie  (global_ie),
  .irq        (irq)
);

// File: tb/bus_attach_detect_tb.sv
module bus_attach_detect_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_in = 1'b1, sda_in = 1'b1, tick_1ms = 1'b0;
  logic       ctrl_wr = 1'b0, flag_clr = 1'b0, global_ie = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic [7:0] ctrl_rdata;
  logic       event_flag, attached, irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state
  logic [1:0] m_s1 = 2'b11, m_s2 = 2'b11;
  int         m_cnt = 0;
  bit         m_att = 1, m_flag = 0, m_ie = 0, m_pol = 0;
  logic [1:0] m_sel = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_attach_detect u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_in),
    .sda_in     (sda_in),
    .tick_1ms   (tick_1ms),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .flag_clr   (flag_clr),
    .global_ie  (global_ie),
    .ctrl_rdata (ctrl_rdata),
    .event_flag (event_flag),
    .attached   (attached),
    .irq        (irq)
  );

  function automatic int ticks_for(input logic [1:0] s);
    case (s)
      2'd0: return 250;
      2'd1: return 500;
      2'd2: return 1000;
      default: return 2000;
    endcase
  endfunction

  function automatic logic [7:0] exp_rdata();
    logic [7:0] v = 8'h00;
    v[6] = m_ie;
    v[2] = m_sel[1];
    v[1] = m_sel[0];
    v[0] = m_pol;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(attached == m_att, "R2_R4 attached", int'(attached), int'(m_att));
    chk(event_flag == m_flag, "R5_R6 event_flag", int'(event_flag), int'(m_flag));
    chk(irq == (m_flag && m_ie && global_ie), "R7 irq", int'(irq),
        int'(m_flag && m_ie && global_ie));
    chk(ctrl_rdata == exp_rdata(), "R8 ctrl_rdata", int'(ctrl_rdata), int'(exp_rdata()));
  endtask

  // one clock: inputs already set; update reference at the edge, compare after it
  task automatic step();
    bit blow, restart_b, disc, conn, setb;
    @(posedge clk);
    blow      = (m_s2 == 2'b00);
    restart_b = ctrl_wr && (ctrl_wdata[2:1] != m_sel);
    disc = 0;
    conn = 0;
    if (m_att) begin
      if (!blow || restart_b) m_cnt = 0;
      else if (tick_1ms) begin
        if (m_cnt + 1 == ticks_for(m_sel)) begin
          disc = 1; m_att = 0; m_cnt = 0;
        end else m_cnt = m_cnt + 1;
      end
    end else begin
      m_cnt = 0;
      if (!blow) begin conn = 1; m_att = 1; end
    end
    setb = m_pol ? disc : conn;
    m_flag = setb || (m_flag && !flag_clr);
    if (ctrl_wr) begin
      m_ie  = ctrl_wdata[6];
      m_sel = ctrl_wdata[2:1];
      m_pol = ctrl_wdata[0];
    end
    m_s2 = m_s1;
    m_s1 = {scl_in, sda_in};
    #1;
    compare_all();
    @(negedge clk);
    ctrl_wr  = 1'b0;
    flag_clr = 1'b0;
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    ctrl_wr = 1'b1;
    ctrl_wdata = v;
    step();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int lim;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(attached == 1'b1, "R10 attached", int'(attached), 1);
    chk(event_flag == 1'b0, "R10 flag", int'(event_flag), 0);
    chk(irq == 1'b0, "R10 irq", int'(irq), 0);
    chk(ctrl_rdata == 8'h00, "R10 ctrl", int'(ctrl_rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reserved bits read zero
    write_ctrl(8'hFF);
    chk(ctrl_rdata == 8'h47, "R8 layout", int'(ctrl_rdata), 8'h47);

    // R1 R2 R5 R7: exact detach timing, select 0, polarity detach
    write_ctrl(8'h41);
    global_ie = 1'b1;
    tick_1ms = 1'b1;
    scl_in = 1'b0; sda_in = 1'b0;
    repeat (251) step();
    chk(attached == 1'b1, "R1 R2 still attached one edge early", int'(attached), 1);
    step();
    chk(attached == 1'b0, "R2 detach at limit", int'(attached), 0);
    chk(event_flag == 1'b1, "R5 detach sets flag with pol=1", int'(event_flag), 1);
    chk(irq == 1'b1, "R7 irq asserted", int'(irq), 1);
    global_ie = 1'b0;
    @(posedge clk); #1;
    chk(irq == 1'b0, "R7 global enable gates irq", int'(irq), 0);
    @(negedge clk);
    global_ie = 1'b1;

    // R4 R5: reattach does not set flag with pol=1; then clear (R6)
    flag_clr = 1'b1;
    sda_in = 1'b1;
    step(); step(); step();
    chk(attached == 1'b1, "R4 reattach", int'(attached), 1);
    chk(event_flag == 1'b0, "R5 R6 attach ignored with pol=1, cleared", int'(event_flag), 0);

    // R6 set wins over clear: pol=0, detach, then attach with simultaneous clear
    write_ctrl(8'h40);
    scl_in = 1'b0; sda_in = 1'b0;
    repeat (253) step();
    chk(attached == 1'b0, "R2 detached again", int'(attached), 0);
    chk(event_flag == 1'b0, "R5 detach ignored with pol=0", int'(event_flag), 0);
    scl_in = 1'b1;
    step(); step();
    flag_clr = 1'b1;
    step();
    chk(attached == 1'b1, "R4 attach", int'(attached), 1);
    chk(event_flag == 1'b1, "R6 set wins over clear", int'(event_flag), 1);
    flag_clr = 1'b1;
    step();
    chk(event_flag == 1'b0, "R6 clear", int'(event_flag), 0);

    // R3: a one-cycle high blip restarts the low count
    scl_in = 1'b0;
    repeat (200) step();
    scl_in = 1'b1; step();
    scl_in = 1'b0;
    repeat (240) step();
    chk(attached == 1'b1, "R3 blip restarted count", int'(attached), 1);

    // R9: select change mid-count restarts from zero
    scl_in = 1'b1; step(); step(); step();
    scl_in = 1'b0;
    repeat (200) step();
    write_ctrl(8'h42);
    repeat (450) step();
    chk(attached == 1'b1, "R9 restart after select change", int'(attached), 1);
    repeat (60) step();
    chk(attached == 1'b0, "R9 detach after full 500", int'(attached), 0);
    scl_in = 1'b1; step(); step(); step();

    // random phase
    for (int seg = 0; seg < 40; seg++) begin
      if ($urandom_range(0, 2) == 0) begin
        ctrl_wr = 1'b1;
        ctrl_wdata = 8'($urandom());
        ctrl_wdata[2] = ($urandom_range(0, 3) == 0);
      end
      lim = ticks_for(m_sel);
      scl_in = 1'b0; sda_in = 1'b0;
      for (int c = 0; c < lim + 40 - int'($urandom_range(0, 80)); c++) begin
        tick_1ms = ($urandom_range(0, 7) != 0);
        flag_clr = ($urandom_range(0, 200) == 0);
        global_ie = ($urandom_range(0, 9) != 0);
        if ($urandom_range(0, 900) == 0) scl_in = 1'b1;
        else if (scl_in && $urandom_range(0, 1) == 0) scl_in = 1'b0;
        step();
      end
      scl_in = $urandom_range(0, 1);
      sda_in = !scl_in;
      for (int c = 0; c < int'($urandom_range(1, 8)); c++) begin
        flag_clr = ($urandom_range(0, 3) == 0);
        step();
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule